// File: doc/BRIEF.md
# Double-and-Add Scalar Multiplication Sequencer

This block runs the control side of a scalar point multiplication k·P. It takes a wide scalar key and drives an external curve arithmetic unit. The sequencer finds the most significant set bit of the key, and the accumulator in the arithmetic unit already holds the base point at that bit. Then, for each lower bit, scanning toward bit 0, it sends one DOUBLE command, followed by an ADD-base-point command if that bit is 1. Each command waits on a valid/ready handshake, and each one must be answered by a done pulse from the arithmetic unit before the sequencer goes on.

A zero key produces the point at infinity and sends no command; a flag reports this case. When a run ends, the block gives a one-cycle completion pulse and holds the number of doubles and adds it sent until the next start. A start seen while the block is busy has no effect.

The controller is a state machine with these states: IDLE (wait for start), LOCATE (find the top set bit or detect zero), STEP (move down one bit or finish), SEND_DBL and SEND_ADD (present a command until it is accepted), WAIT_DBL and WAIT_ADD (wait for the unit's done pulse), and FINISH (completion pulse). Its transitions are:
- IDLE→LOCATE on start.
- LOCATE→FINISH for a zero key, and LOCATE→STEP otherwise.
- STEP→FINISH at bit 0, and STEP→SEND_DBL otherwise.
- SEND_DBL→WAIT_DBL on ready.
- WAIT_DBL→SEND_ADD when the current bit is 1, and WAIT_DBL→STEP when it is 0, in both cases on op_done.
- SEND_ADD→WAIT_ADD on ready.
- WAIT_ADD→STEP on op_done.
- FINISH→IDLE.

Top module: `ecpm_ladder_seq`

## Requirements
- R1: After reset, and between runs, busy is 0 and no command is offered. A start while idle captures key, and busy is 1 from the next cycle until the completion pulse.
- R2: A zero key sends no command. It ends with done, key_zero=1, and both counts equal to 0.
- R3: Key bits above the top set bit are skipped. The top set bit itself causes no command, so the first command is a DOUBLE for the bit just below it.
- R4: For each bit from top−1 down to 0, the block sends DOUBLE and then, if that bit is 1, ADD. cmd_op encodes DOUBLE as 0 and ADD as 1. Applied to an accumulator that starts at 1, these commands yield the key.
- R5: At completion, dbl_count equals the index of the top set bit and add_count equals the key's Hamming weight minus one.
- R6: While cmd_valid=1 and cmd_ready=0, the command stays offered with the same cmd_op on the next cycle.
- R7: After a command is accepted, no new command is offered until op_done is seen. An op_done that arrives while no command is outstanding has no effect on the sequence.
- R8: done is a single-cycle pulse. The counts and key_zero keep their values after done until the next accepted start.
- R9: A start, or a change of key, while busy does not change the running sequence or its result.
- R10: A key of 1 completes with no command, key_zero=0 and both counts equal to 0.
- R11: A key with its top bit set sends exactly KEY_W−1 doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a multiplication (used only when idle) |
| key | input | KEY_W | Scalar key, captured on start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| key_zero | output | 1 | Last key was zero (result is the point at infinity) |
| cmd_valid | output | 1 | Command offered to the arithmetic unit |
| cmd_op | output | 1 | 0 = DOUBLE, 1 = ADD base point |
| cmd_ready | input | 1 | Arithmetic unit accepts the command |
| op_done | input | 1 | Arithmetic unit finished the accepted command |
| dbl_count | output | $clog2(KEY_W+1) | Doubles sent in the last run |
| add_count | output | $clog2(KEY_W+1) | Adds sent in the last run |

## Verification
The hardest situation to reach from the ports is an op_done that arrives while the sequencer is offering a command or stepping. To reach it, the bench models the arithmetic unit with stray done pulses on every idle cycle, and combines this with a randomly withheld ready and a varying reply delay. A scoreboard checks that the order of commands is unchanged under these conditions. Two further cases are covered: a start and key change injected in the middle of a long run, and full-width keys that drive the bit index down from its largest value.

// File: rtl/ecpm_pkg.sv
package ecpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCATE,
        ST_STEP,
        ST_SEND_DBL,
        ST_WAIT_DBL,
        ST_SEND_ADD,
        ST_WAIT_ADD,
        ST_FINISH
    } seq_state_e;

    typedef enum logic {
        OP_DOUBLE = 1'b0,
        OP_ADD    = 1'b1
    } pt_op_e;

endpackage

// File: rtl/ecpm_msb_finder.sv
module ecpm_msb_finder #(
    parameter int VEC_W = 191,
    parameter int IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Highest set bit wins: later loop iterations override earlier ones.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < VEC_W; i++) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ecpm_op_counter.sv
module ecpm_op_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    // R5: count never wraps within a run
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (count != {CNT_W{1'b1}}));

endmodule

// File: rtl/ecpm_seq_fsm.sv
module ecpm_seq_fsm
    import ecpm_pkg::*;
#(
    parameter int KEY_W = 191,
    parameter int IDX_W = $clog2(KEY_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    input  logic             cmd_ready,
    input  logic             op_done,
    input  logic             msb_any,
    input  logic [IDX_W-1:0] msb_idx,
    output logic [KEY_W-1:0] key_q,
    output logic             busy,
    output logic             done,
    output logic             key_zero,
    output logic             cmd_valid,
    output logic             cmd_op,
    output logic             cnt_clr,
    output logic             dbl_inc,
    output logic             add_inc
);

    seq_state_e       state, state_nx;
    logic [IDX_W-1:0] bit_idx;
    logic             zero_q;
    logic             start_ok;
    logic             cur_bit;

    assign start_ok = (state == ST_IDLE) && start;
    assign cur_bit  = key_q[bit_idx];
    assign key_zero = zero_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Key capture, bit index and zero flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q   <= '0;
            bit_idx <= '0;
            zero_q  <= 1'b0;
        end else begin
            if (start_ok) begin
                key_q  <= key;
                zero_q <= 1'b0;
            end
            if (state == ST_LOCATE) begin
                bit_idx <= msb_idx;
                zero_q  <= !msb_any;
            end
            if ((state == ST_STEP) && (bit_idx != '0)) begin
                bit_idx <= bit_idx - IDX_W'(1);
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start)     state_nx = ST_LOCATE;
            ST_LOCATE:   state_nx = msb_any ? ST_STEP : ST_FINISH;
            ST_STEP:     state_nx = (bit_idx == '0) ? ST_FINISH : ST_SEND_DBL;
            ST_SEND_DBL: if (cmd_ready) state_nx = ST_WAIT_DBL;
            ST_WAIT_DBL: if (op_done)   state_nx = cur_bit ? ST_SEND_ADD : ST_STEP;
            ST_SEND_ADD: if (cmd_ready) state_nx = ST_WAIT_ADD;
            ST_WAIT_ADD: if (op_done)   state_nx = ST_STEP;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        cmd_valid = (state == ST_SEND_DBL) || (state == ST_SEND_ADD);
        cmd_op    = (state == ST_SEND_ADD) ? OP_ADD : OP_DOUBLE;
        cnt_clr   = start_ok;
        dbl_inc   = (state == ST_SEND_DBL) && cmd_ready;
        add_inc   = (state == ST_SEND_ADD) && cmd_ready;
    end

    // R6: an offered command is held until accepted
    a_r6_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op)));

    // R7: acceptance is followed by a gap before the next command
    a_r7_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: a zero key never offers a command
    a_r2_zero_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        key_zero |-> !cmd_valid);

    // R1: no command while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    // R9: captured key stays fixed during a run
    a_r9_key_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(key_q));

endmodule

// File: rtl/ecpm_ladder_seq.sv
module ecpm_ladder_seq #(
    parameter int KEY_W = 191,
    localparam int IDX_W = $clog2(KEY_W),
    localparam int CNT_W = $clog2(KEY_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    output logic             busy,
    output logic             done,
    output logic             key_zero,
    output logic             cmd_valid,
    output logic             cmd_op,
    input  logic             cmd_ready,
    input  logic             op_done,
    output logic [CNT_W-1:0] dbl_count,
    output logic [CNT_W-1:0] add_count
);

    logic [KEY_W-1:0] key_q;
    logic             msb_any;
    logic [IDX_W-1:0] msb_idx;
    logic             cnt_clr;
    logic             dbl_inc;
    logic             add_inc;

    ecpm_msb_finder #(
        .VEC_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_msb (
        .vec (key_q),
        .any (msb_any),
        .idx (msb_idx)
    );

    ecpm_seq_fsm #(
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key       (key),
        .cmd_ready (cmd_ready),
        .op_done   (op_done),
        .msb_any   (msb_any),
        .msb_idx   (msb_idx),
        .key_q     (key_q),
        .busy      (busy),
        .done      (done),
        .key_zero  (key_zero),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cnt_clr   (cnt_clr),
        .dbl_inc   (dbl_inc),
        .add_inc   (add_inc)
    );

    ecpm_op_counter #(.CNT_W (CNT_W)) u_dbl_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (dbl_inc),
        .count (dbl_count)
    );

    ecpm_op_counter #(.CNT_W (CNT_W)) u_add_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (add_inc),
        .count (add_count)
    );

    // R11 / R5: doubles never exceed KEY_W-1
    a_r11_dbl_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dbl_count < CNT_W'(KEY_W)));

    // R3: adds never outnumber doubles
    a_r3_add_le_dbl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (add_count <= dbl_count));

endmodule

// File: tb/test_ecpm_ladder_seq.sv
`timescale 1ns/1ps
module test_ecpm_ladder_seq;

    localparam int KW = 191;
    localparam int CW = $clog2(KW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [KW-1:0] key = '0;
    logic          busy, done, key_zero, cmd_valid, cmd_op;
    logic          cmd_ready = 1'b0;
    logic          op_done = 1'b0;
    logic [CW-1:0] dbl_count, add_count;

    ecpm_ladder_seq #(.KEY_W (KW)) i_ecpm_ladder_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .key       (key),
        .busy      (busy),
        .done      (done),
        .key_zero  (key_zero),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_ready (cmd_ready),
        .op_done   (op_done),
        .dbl_count (dbl_count),
        .add_count (add_count)
    );

    always #4 clk = ~clk;   // 125 MHz

    int            n_chk = 0;
    int            n_fail = 0;
    logic          exp_q[$];
    logic [KW-1:0] acc;
    bit            outstanding = 0;
    int            cd = 0;
    int            rdy_mode = 0;
    int            dly = 0;
    bit            spurious = 0;
    bit            hold_pend = 0;
    logic          hold_op = 1'b0;

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    // Arithmetic unit model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            cmd_ready = 1'b0;
            op_done   = 1'b0;
            outstanding = 0;
            hold_pend = 0;
        end else begin
            logic r;
            op_done = 1'b0;
            if (outstanding) begin
                if (cd == 0) begin
                    op_done = 1'b1;
                    outstanding = 0;
                end else begin
                    cd--;
                end
            end else if (spurious) begin
                op_done = 1'b1;      // stray done, must be ignored (R7)
            end
            if (hold_pend)
                check(cmd_valid === 1'b1 && cmd_op === hold_op,
                      $sformatf("R6 hold: valid=%0b op=%0b expected valid=1 op=%0b",
                                cmd_valid, cmd_op, hold_op));
            if (cmd_valid && outstanding)
                check(0, "R7 command offered while one outstanding: valid=1 expected 0");
            case (rdy_mode)
                0:       r = 1'b1;
                default: r = ($urandom % 3) == 0;
            endcase
            cmd_ready = r;
            hold_pend = cmd_valid && !r;
            hold_op   = cmd_op;
            if (cmd_valid && r) begin
                if (exp_q.size() == 0) begin
                    check(0, $sformatf("R3/R4 unexpected command op=%0b expected none", cmd_op));
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    check(cmd_op === e,
                          $sformatf("R3/R4 command order: op=%0b expected %0b", cmd_op, e));
                end
                if (cmd_op) acc = acc + KW'(1);
                else        acc = acc << 1;
                outstanding = 1;
                cd = dly;
            end
        end
    end

    function automatic logic [KW-1:0] rnd_key(input int dens);
        logic [KW-1:0] v;
        for (int i = 0; i < KW; i++) v[i] = (($urandom % dens) == 0);
        return v;
    endfunction

    task automatic run_key(input logic [KW-1:0] k, input int mode, input int d,
                           input bit spur, input bit poke, input string tag);
        int msb = -1;
        int wt = 0;
        int cyc = 0;
        int e_dbl, e_add;
        for (int i = 0; i < KW; i++) if (k[i]) begin msb = i; wt++; end
        e_dbl = (msb > 0) ? msb : 0;
        e_add = (wt > 0) ? wt - 1 : 0;
        exp_q.delete();
        for (int i = msb - 1; i >= 0; i--) begin
            exp_q.push_back(1'b0);
            if (k[i]) exp_q.push_back(1'b1);
        end
        acc = (k != '0) ? KW'(1) : '0;
        rdy_mode = mode;
        dly = d;
        spurious = spur;
        @(negedge clk);
        key = k;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, $sformatf("R1 %s busy after start: %0b expected 1", tag, busy));
        if (poke) begin
            repeat (5) @(negedge clk);
            key = ~k;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        if (done !== 1'b1) begin
            check(0, $sformatf("R1 %s timeout waiting for done: 0 expected 1", tag));
            return;
        end
        check(dbl_count == CW'(e_dbl),
              $sformatf("R5 %s dbl_count=%0d expected %0d", tag, dbl_count, e_dbl));
        check(add_count == CW'(e_add),
              $sformatf("R5 %s add_count=%0d expected %0d", tag, add_count, e_add));
        check(key_zero === (k == '0),
              $sformatf("R2 %s key_zero=%0b expected %0b", tag, key_zero, (k == '0)));
        check(exp_q.size() == 0,
              $sformatf("R4 %s commands missing: %0d left expected 0", tag, exp_q.size()));
        if (k != '0)
            check(acc == k, $sformatf("R4 %s accumulated=%h expected %h", tag, acc, k));
        @(negedge clk);
        check(done === 1'b0, $sformatf("R8 %s done held: %0b expected 0", tag, done));
        check(busy === 1'b0, $sformatf("R1 %s busy after done: %0b expected 0", tag, busy));
        repeat (3) @(negedge clk);
        check(dbl_count == CW'(e_dbl) && add_count == CW'(e_add) && key_zero === (k == '0),
              $sformatf("R8 %s counts held: %0d/%0d expected %0d/%0d",
                        tag, dbl_count, add_count, e_dbl, e_add));
        spurious = 0;
    endtask

    initial begin
        logic [KW-1:0] kk;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 0 && done === 0 && cmd_valid === 0 && key_zero === 0 &&
              dbl_count == 0 && add_count == 0,
              $sformatf("R1 reset state busy=%0b done=%0b valid=%0b zero=%0b expected all 0",
                        busy, done, cmd_valid, key_zero));

        run_key('0, 0, 0, 0, 0, "zero R2");
        run_key(KW'(1), 0, 0, 0, 0, "one R10");
        run_key(KW'(2), 0, 1, 0, 0, "two R3");
        run_key(KW'(3), 1, 2, 0, 0, "three R4");
        run_key(KW'(11), 1, 0, 1, 0, "eleven R7");
        kk = '0; kk[KW-1] = 1'b1;
        run_key(kk, 0, 0, 0, 0, "top bit R11");
        kk[0] = 1'b1;
        run_key(kk, 1, 1, 1, 0, "top+low R11");
        run_key('1, 1, 2, 0, 0, "all ones R11");
        run_key(rnd_key(2), 1, 3, 1, 1, "random busy poke R9");
        run_key(rnd_key(2) >> 120, 1, 1, 0, 0, "leading zeros R3");
        run_key(rnd_key(8), 0, 0, 1, 0, "sparse R7");
        run_key(rnd_key(3), 1, 2, 0, 1, "poke2 R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: run hung, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule